// File: doc/BRIEF.md
# Carry-Bypass Block Adder

This block adds two unsigned operands and a carry-in. It produces a sum of the same width and a carry-out. The operand width is divided into equal sections. Inside each section every bit position classifies itself as generating, propagating or deleting a carry, and the carry ripples through the section one bit at a time. Each section also forms a group-propagate term. When every bit in the section propagates, a multiplexer hands the section's incoming carry directly to the next section and skips the ripple chain.

The adder core is purely combinational. The top module places one register stage on the result, so that the outputs are clean and easy to observe at the clock. That register clears asynchronously on an active-low reset. The defaults are a 16-bit width and four 4-bit sections, chained from the least significant section upward.

Top module: `cba_adder`

## Requirements
- R1: One clock edge after `a`, `b` and `c_in` are sampled with reset released, `{c_out, sum}` equals the 17-bit arithmetic value a + b + c_in. This holds for every input combination.
- R2: While `rst_n` is low, `sum` and `c_out` are 0. The clear is asynchronous.
- R3: When every bit position propagates (a XOR b is all ones), the carry-in passes through all sections. `c_out` then equals `c_in`, and every bit of `sum` equals the inverse of `c_in`. Example: 0xFFFF + 0x0000 + 1 gives sum 0x0000 and c_out 1.
- R4: When every bit position deletes (a OR b is zero), `c_out` is 0. `sum` is then `c_in` in bit 0 and zero in all other bits.
- R5: When every bit position generates (a AND b is all ones), `c_out` is 1. `sum` then has ones in bits 15..1 and `c_in` in bit 0.
- R6: A carry that leaves one section enters the next. This includes a carry that crosses a section whose bits all propagate. Examples: 0x00FF + 0x0001 = 0x0100, and 0x0F0F + 0x00F1 = 0x1000.
- R7: Alternating operand patterns give the R1 result. 0xAAAA + 0x5555 + 1 = 0x10000, where every bit propagates. 0xAAAA + 0xAAAA = 0x15554, where generate and delete alternate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low clear of the result register |
| a | input | WIDTH (16) | First operand |
| b | input | WIDTH (16) | Second operand |
| c_in | input | 1 | Carry into the least significant section |
| sum | output | WIDTH (16) | Registered sum |
| c_out | output | 1 | Registered carry out of the top section |

## Verification
Each result becomes visible exactly one rising edge after its operands are captured. The bench drives operands on a falling edge, lets one rising edge pass, and compares `sum` and `c_out` on the next falling edge, before it applies new operands. The reset clear does not wait for a clock, so that check samples a short delay after `rst_n` falls. The assertions use the same one-edge lag: they compare the present outputs with `$past` of the operands.

// File: rtl/cba_adder.sv
module cba_adder #(
  parameter int WIDTH = 16,
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out
);
  localparam int NSEC = WIDTH / SEC_W;

  logic [WIDTH-1:0] gen, prp, del, cbit, sum_c;
  logic [NSEC:0]    sc;

  assign gen   = a & b;
  assign prp   = a ^ b;
  assign del   = ~a & ~b;
  assign sc[0] = c_in;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [SEC_W:0] ch;
    logic           skip;
    assign ch[0] = sc[s];
    for (genvar j = 0; j < SEC_W; j++) begin : g_bit
      assign ch[j+1]           = gen[s*SEC_W+j] | (~del[s*SEC_W+j] & ch[j]);
      assign cbit[s*SEC_W+j]   = ch[j];
    end
    assign skip    = &prp[s*SEC_W +: SEC_W];
    assign sc[s+1] = skip ? sc[s] : ch[SEC_W];
  end

  assign sum_c = prp ^ cbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      c_out <= 1'b0;
    end else begin
      sum   <= sum_c;
      c_out <= sc[NSEC];
    end
  end
endmodule

// File: rtl/cba_adder_chk.sv
module cba_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             c_in,
  input logic [WIDTH-1:0] sum,
  input logic             c_out
);
  a_r1_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> {c_out, sum} ==
      $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c_in}));

  a_r2_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (sum == '0 && !c_out));

  a_r3_full_skip: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(&(a ^ b))) |->
      (c_out == $past(c_in) && sum == {WIDTH{~$past(c_in)}}));

  a_r4_all_delete: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past((a | b) == '0)) |->
      (!c_out && sum == {{(WIDTH-1){1'b0}}, $past(c_in)}));

  a_r5_all_generate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(&(a & b))) |->
      (c_out && sum == {{(WIDTH-1){1'b1}}, $past(c_in)}));
endmodule

bind cba_adder cba_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_cba_adder.sv
module tb_cba_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        c_in = 1'b0;
  logic [15:0] sum;
  logic        c_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  cba_adder dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .c_in(c_in),
                 .sum(sum), .c_out(c_out));

  // {a, b, c_in, expected 17-bit result}
  localparam logic [49:0] VEC [12] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'h0001, 16'h0001, 1'b0, 17'h00002},
    {16'h00FF, 16'h0001, 1'b0, 17'h00100},
    {16'h0F0F, 16'h00F1, 1'b0, 17'h01000},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'hAAAA, 16'hAAAA, 1'b0, 17'h15554},
    {16'h1234, 16'h4321, 1'b1, 17'h05556},
    {16'hFFFF, 16'h0001, 1'b0, 17'h10000},
    {16'h8000, 16'h8000, 1'b1, 17'h10001},
    {16'h7FFF, 16'h0000, 1'b1, 17'h08000},
    {16'hF0F0, 16'h0F0F, 1'b1, 17'h10000},
    {16'h5555, 16'h5555, 1'b1, 17'h0AAAB}
  };

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%05h expected=%05h", req, got, exp);
    end
  endtask

  task automatic run(input logic [15:0] va, input logic [15:0] vb, input logic vc,
                     input logic [16:0] exp, input string req);
    @(negedge clk);
    a = va; b = vb; c_in = vc;
    @(posedge clk);
    @(negedge clk);
    check(req, {c_out, sum}, exp);
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog got=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset state", {c_out, sum}, 17'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++)
      run(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], "R1/R6/R7 table");

    run(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R3 full skip cin=1");
    run(16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, "R3 full skip cin=0");
    run(16'h0000, 16'h0000, 1'b1, 17'h00001, "R4 all delete cin=1");
    run(16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE, "R5 all generate cin=0");
    run(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R5 all generate cin=1");
    run(16'h0FF0, 16'h0010, 1'b0, 17'h01000, "R6 carry across skipped section");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      logic        rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      run(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0, rc}, "R1 random");
    end

    run(16'h1234, 16'h1111, 1'b0, 17'h02345, "R1 before reset");
    #1 rst_n = 1'b0;
    #1 check("R2 async clear", {c_out, sum}, 17'h0);
    @(negedge clk);
    check("R2 held in reset", {c_out, sum}, 17'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule